// File: doc/BRIEF.md
# Full-Bridge Shoot-Through Guard

This block sits between a PWM or current controller and the gate drivers of an H-bridge. It handles two half-bridge legs, A and B. Each leg has a high-side and a low-side command and drives one high-side and one low-side gate enable. Commands are resynchronised to the local clock. The block then applies a fixed priority that never lets both switches of a leg conduct. The low-side command wins over the high-side command, and a global off request or an undervoltage fault wins over both.

Each turn-on is delayed by a programmable dead time counted in clock cycles. There is one dead time for the high sides and one for the low sides, and both legs use them. Turn-off is never delayed. If a leg's high-side command is tied high, its low-side command alone switches the leg between its two states, with the dead time inserted at each change.

Whenever the bridge comes out of reset, an off request or a fault, a recovery sequence runs. Both low sides first pulse on for a fixed number of cycles to recharge the bootstrap capacitors. The high sides stay blocked until a longer upper-enable interval has passed.

Top module: `fb_gate_guard`

## Requirements
- R1: While `bridge_off` is 1, all four gate outputs are 0 in that same cycle, whatever the other inputs are.
- R2: While `uv_fault` is 1, all four gate outputs are 0 in that same cycle, exactly as for R1.
- R3: In a leg whose synchronised low-side command is 1, the high gate is 0. The low gate turns on after the low dead time, whatever the high-side command is.
- R4: A leg's high gate can be 1 only while its synchronised commands are high=1 and low=0. With both commands at 0 both gates are 0. The two gates of one leg are never 1 together.
- R5: A high gate turns on once its request has been present for `hi_dead` cycles. Counting the two synchroniser stages, it rises after posedge 2+`hi_dead` following the command change, and it falls after posedge 2 with no added delay.
- R6: A low gate behaves the same way with `lo_dead`: it rises after posedge 2+`lo_dead` and falls after posedge 2.
- R7: With the high command held at 1, toggling the low command switches the leg between low-on and high-on. Both gates are 0 for the dead time in between.
- R8: A command pulse that lasts no more cycles than the dead time produces no output pulse. A pulse one cycle longer produces exactly one cycle of output.
- R9: After reset, `bridge_off` or `uv_fault` is released, both low gates are 1 from the first posedge through posedge `REFRESH_CYC`, whatever the commands are. After that the low gates follow their commands.
- R10: After that same release, no high gate is 1 before posedge `UPEN_CYC`+1+`hi_dead`.
- R11: Legs A and B are independent of each other. They share only `bridge_off`, `uv_fault` and the two dead-time settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts the recovery sequence |
| bridge_off | input | 1 | Global off request, highest priority |
| uv_fault | input | 1 | Undervoltage fault flag, same effect as bridge_off |
| a_hi_cmd | input | 1 | Leg A high-side command (asynchronous) |
| a_lo_cmd | input | 1 | Leg A low-side command (asynchronous) |
| b_hi_cmd | input | 1 | Leg B high-side command (asynchronous) |
| b_lo_cmd | input | 1 | Leg B low-side command (asynchronous) |
| hi_dead | input | DT_W | High-side turn-on delay in cycles |
| lo_dead | input | DT_W | Low-side turn-on delay in cycles |
| a_hi_gate | output | 1 | Leg A high-side gate enable |
| a_lo_gate | output | 1 | Leg A low-side gate enable |
| b_hi_gate | output | 1 | Leg B high-side gate enable |
| b_lo_gate | output | 1 | Leg B low-side gate enable |

## Verification
The bench builds the block with `DT_W`=4, `REFRESH_CYC`=6 and `UPEN_CYC`=9, and drives `hi_dead`=3 and `lo_dead`=2. With these values a whole recovery sequence takes about a dozen cycles, so each edge of the refresh window and of the upper-enable window can be sampled on its exact cycle. Because the two dead times differ, a swap between the high and low settings shows up as a shifted edge. Dead times of two and three cycles are short enough to probe pulses at the dead time and one cycle longer, which shows both suppression and the one-cycle output.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_cmd_t;

  // Saturating increment used by every dwell counter.
  function automatic logic [15:0] sat_inc(input logic [15:0] cnt, input logic [15:0] top);
    return (cnt >= top) ? cnt : cnt + 16'd1;
  endfunction

  // A request has dwelled long enough once its counter reaches the limit.
  function automatic logic dwell_done(input logic [15:0] cnt, input logic [15:0] lim);
    return cnt >= lim;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      stage[0] <= d;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hbg_recovery.sv
module hbg_recovery #(
  parameter int unsigned REFRESH_CYC = 41,
  parameter int unsigned UPEN_CYC    = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  output logic run,
  output logic refresh,
  output logic upper_ok
);
  localparam int unsigned CW = $clog2(UPEN_CYC + 1);
  localparam logic [CW-1:0] REF_L = CW'(REFRESH_CYC);
  localparam logic [CW-1:0] UPEN_L = CW'(UPEN_CYC);

  logic          live_q;
  logic [CW-1:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      rel_cnt <= '0;
    end else begin
      live_q <= !halt;
      if (!live_q || halt) rel_cnt <= '0;
      else rel_cnt <= CW'(hbg_pkg::sat_inc(16'(rel_cnt), 16'(UPEN_L)));
    end
  end

  assign run      = live_q && !halt;
  assign refresh  = run && (rel_cnt < REF_L);
  assign upper_ok = run && hbg_pkg::dwell_done(16'(rel_cnt), 16'(UPEN_L));

  AST_UPPER_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    upper_ok |-> !refresh); // R10
  AST_RECOVERY_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !refresh && !upper_ok); // R9
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg #(
  parameter int unsigned DT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              halt,
  input  logic              run,
  input  logic              refresh,
  input  logic              upper_ok,
  input  hbg_pkg::leg_cmd_t cmd,
  input  logic [DT_W-1:0]   dt_hi,
  input  logic [DT_W-1:0]   dt_lo,
  output logic              gate_hi,
  output logic              gate_lo
);
  localparam int unsigned CMAX = (1 << DT_W) - 1;

  logic            want_hi, want_lo, hi_ready, lo_ready;
  logic [DT_W-1:0] hi_cnt, lo_cnt;

  // Low-side command outranks the high-side command.
  assign want_hi = run && upper_ok && !refresh && cmd.hi && !cmd.lo;
  assign want_lo = run && cmd.lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else begin
      hi_cnt <= want_hi ? DT_W'(hbg_pkg::sat_inc(16'(hi_cnt), 16'(CMAX))) : '0;
      lo_cnt <= want_lo ? DT_W'(hbg_pkg::sat_inc(16'(lo_cnt), 16'(CMAX))) : '0;
    end
  end

  assign hi_ready = hbg_pkg::dwell_done(16'(hi_cnt), 16'(dt_hi));
  assign lo_ready = hbg_pkg::dwell_done(16'(lo_cnt), 16'(dt_lo));

  assign gate_hi = !halt && want_hi && hi_ready;
  assign gate_lo = !halt && (refresh || (want_lo && lo_ready));

  AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo)); // R4
  AST_LO_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.lo |-> !gate_hi); // R3
  AST_HI_OFF_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd.hi |-> !gate_hi); // R5
  AST_HI_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_hi != '0) && $rose(gate_hi) |-> $past(want_hi)); // R5
  AST_LO_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_lo != '0) && !refresh && $rose(gate_lo) |-> $past(want_lo)); // R6
endmodule

// File: rtl/fb_gate_guard.sv
module fb_gate_guard #(
  parameter int unsigned DT_W        = 8,
  parameter int unsigned REFRESH_CYC = 41,
  parameter int unsigned UPEN_CYC    = 45,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bridge_off,
  input  logic            uv_fault,
  input  logic            a_hi_cmd,
  input  logic            a_lo_cmd,
  input  logic            b_hi_cmd,
  input  logic            b_lo_cmd,
  input  logic [DT_W-1:0] hi_dead,
  input  logic [DT_W-1:0] lo_dead,
  output logic            a_hi_gate,
  output logic            a_lo_gate,
  output logic            b_hi_gate,
  output logic            b_lo_gate
);
  localparam int unsigned LEGS = 2;

  logic                            halt, run, refresh, upper_ok;
  logic [2*LEGS-1:0]               cmd_s;
  hbg_pkg::leg_cmd_t [LEGS-1:0]    leg_cmd;
  logic [LEGS-1:0]                 g_hi, g_lo;

  // Off request and fault act without any clock latency.
  assign halt = bridge_off | uv_fault;

  hbg_sync #(.W(2*LEGS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({b_hi_cmd, b_lo_cmd, a_hi_cmd, a_lo_cmd}),
    .q     (cmd_s)
  );

  hbg_recovery #(.REFRESH_CYC(REFRESH_CYC), .UPEN_CYC(UPEN_CYC)) u_recovery (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt     (halt),
    .run      (run),
    .refresh  (refresh),
    .upper_ok (upper_ok)
  );

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    assign leg_cmd[i] = hbg_pkg::leg_cmd_t'(cmd_s[2*i+1 -: 2]);
    hbg_leg #(.DT_W(DT_W)) u_leg (
      .clk      (clk),
      .rst_n    (rst_n),
      .halt     (halt),
      .run      (run),
      .refresh  (refresh),
      .upper_ok (upper_ok),
      .cmd      (leg_cmd[i]),
      .dt_hi    (hi_dead),
      .dt_lo    (lo_dead),
      .gate_hi  (g_hi[i]),
      .gate_lo  (g_lo[i])
    );
  end

  assign a_hi_gate = g_hi[0];
  assign a_lo_gate = g_lo[0];
  assign b_hi_gate = g_hi[1];
  assign b_lo_gate = g_lo[1];

  AST_OFF_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_off |-> !(a_hi_gate || a_lo_gate || b_hi_gate || b_lo_gate)); // R1
  AST_UV_KILLS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    uv_fault |-> !(a_hi_gate || a_lo_gate || b_hi_gate || b_lo_gate)); // R2
  AST_REFRESH_LOWS: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |-> a_lo_gate && b_lo_gate && !a_hi_gate && !b_hi_gate); // R9
  AST_UPPER_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !upper_ok |-> !a_hi_gate && !b_hi_gate); // R10
endmodule

// File: tb/fb_gate_guard_test.sv
module fb_gate_guard_test;
  localparam int unsigned DT_W = 4;
  localparam int unsigned REF  = 6;
  localparam int unsigned UPEN = 9;
  localparam int unsigned DTH  = 3;
  localparam int unsigned DTL  = 2;

  // {off, uv, a_hi, a_lo, b_hi, b_lo, exp a_hi, exp a_lo, exp b_hi, exp b_lo}
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    10'b00_1001_1001,  // R4 R11: A high-on, B low-on
    10'b00_1110_0110,  // R3: A low wins over high; B high-on
    10'b00_0011_0001,  // R3 R4: A idle, B both -> low
    10'b00_0100_0100,  // R11: only A low
    10'b10_1010_0000,  // R1: off request
    10'b00_1010_1010,  // R10: highs return after recovery
    10'b01_0101_0000,  // R2: fault
    10'b00_0101_0101,  // R9: lows after refresh
    10'b00_0000_0000,  // R4: all idle
    10'b11_1111_0000,  // R1 R2: both kill sources
    10'b00_1111_0101   // R3: both legs low priority
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bridge_off = 1'b0, uv_fault = 1'b0;
  logic a_hi = 1'b0, a_lo = 1'b0, b_hi = 1'b0, b_lo = 1'b0;
  logic a_hi_gate, a_lo_gate, b_hi_gate, b_lo_gate;
  logic [3:0] outs;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fb_gate_guard #(.DT_W(DT_W), .REFRESH_CYC(REF), .UPEN_CYC(UPEN), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .bridge_off(bridge_off), .uv_fault(uv_fault),
    .a_hi_cmd(a_hi), .a_lo_cmd(a_lo), .b_hi_cmd(b_hi), .b_lo_cmd(b_lo),
    .hi_dead(DT_W'(DTH)), .lo_dead(DT_W'(DTL)),
    .a_hi_gate(a_hi_gate), .a_lo_gate(a_lo_gate),
    .b_hi_gate(b_hi_gate), .b_lo_gate(b_lo_gate)
  );

  assign outs = {a_hi_gate, a_lo_gate, b_hi_gate, b_lo_gate};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_n(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts cycles in which a chosen output bit is high over n samples.
  task automatic count_high(input int bit_idx, input int n, output int cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      step(1);
      if (outs[bit_idx]) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    step(3);
    check("R9 reset holds gates low", outs, 4'b0000);

    // Reset release starts refresh.
    rst_n = 1'b1;
    step(1);
    check("R9 refresh first cycle", outs, 4'b0101);
    step(REF - 1);
    check("R9 refresh last cycle", outs, 4'b0101);
    step(1);
    check("R9 refresh over", outs, 4'b0000);

    // Off request with a high-side command pending.
    bridge_off = 1'b1; a_hi = 1'b1;
    #1 check("R1 off immediate", outs, 4'b0000);
    step(5);
    check("R1 off overrides command", outs, 4'b0000);
    bridge_off = 1'b0;
    step(1);
    check("R9 refresh after off", outs, 4'b0101);
    step(REF);
    check("R9 lows release", outs, 4'b0000);
    step(UPEN + DTH - REF - 1);
    check("R10 high still blocked", outs, 4'b0000);
    step(1);
    check("R10 high first allowed", outs, 4'b1000);

    // Bistate: high held, low toggles.
    a_lo = 1'b1;
    step(1);
    check("R7 sync latency", outs, 4'b1000);
    step(1);
    check("R5 high off immediate", outs, 4'b0000);
    step(1);
    check("R6 low dead time", outs, 4'b0000);
    step(1);
    check("R6 R7 low on", outs, 4'b0100);
    a_lo = 1'b0;
    step(1);
    check("R7 low held in sync", outs, 4'b0100);
    step(1);
    check("R6 low off immediate", outs, 4'b0000);
    step(2);
    check("R5 high dead time", outs, 4'b0000);
    step(1);
    check("R5 R7 high on", outs, 4'b1000);

    // Short low pulses.
    a_lo = 1'b1; step(DTL); a_lo = 1'b0;
    count_high(2, 12, c);
    check_n("R8 low pulse at dead time suppressed", c, 0);
    check("R8 high back", outs, 4'b1000);
    a_lo = 1'b1; step(DTL + 1); a_lo = 1'b0;
    count_high(2, 12, c);
    check_n("R6 low pulse one longer", c, 1);

    // Short high pulses.
    a_hi = 1'b0; step(10);
    check("R4 both commands low", outs, 4'b0000);
    a_hi = 1'b1; step(DTH); a_hi = 1'b0;
    count_high(3, 12, c);
    check_n("R8 high pulse at dead time suppressed", c, 0);
    a_hi = 1'b1; step(DTH + 1); a_hi = 1'b0;
    count_high(3, 12, c);
    check_n("R5 high pulse one longer", c, 1);

    // Fault removes an active low gate at once.
    a_lo = 1'b1; step(10);
    check("R3 low on", outs, 4'b0100);
    uv_fault = 1'b1;
    #1 check("R2 fault immediate", outs, 4'b0000);
    step(3);
    uv_fault = 1'b0;
    step(20);

    // Steady-state vector walk.
    for (int v = 0; v < NV; v++) begin
      {bridge_off, uv_fault, a_hi, a_lo, b_hi, b_lo} = VEC[v][9:4];
      step(20);
      check($sformatf("R11 vector %0d", v), outs, VEC[v][3:0]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule